// File: doc/BRIEF.md
# Time-of-Day Clock with Interval Timer

The block keeps the time of day as four cascaded counters: 1/128-second parts, seconds, minutes and hours. A single-cycle 128 Hz strobe from outside advances the chain while the run bit is set. Each counter wraps to zero at its top and passes one carry to the next counter up.

Next to the clock sits an 8-bit interval counter. It counts carry events of one of four timebases and raises a sticky interrupt flag when its count reaches a programmed limit. In auto-reload mode it starts again from zero after each match. In one-shot mode it stops by clearing its own enable bit.

Software reaches every register through a simple write port (enable, address, data) and an asynchronous read port (address, data). The time registers can be loaded at any moment, and counting carries on from the loaded value.

Top module: `interval_rtc`

## Requirements
- R1: After reset every register reads 0: control, limit and the four time registers. irq_o is low.
- R2: While the run bit (control bit 0) is 1, each cycle with tick_i high advances the 1/128 count (address 2). The count runs 0..127, and the step from 127 to 0 adds one to the seconds count (address 3).
- R3: Seconds (address 3) and minutes (address 4) run 0..59, and hours (address 5) run 0..23. Each wrap to 0 carries once into the next counter, and 23:59:59 plus 127/128 goes to all zero on one tick.
- R4: While the run bit is 0, tick_i changes none of the time registers.
- R5: A write to address 2, 3, 4 or 5 loads the low 7, 6, 6 or 5 data bits on the next edge. A value at or above the counter's top goes to 0 on its next step and carries. Carries in the write cycle are taken from the old values.
- R6: While the enable bit (control bit 1) is 1, the interval counter advances once per event of the timebase chosen by control bits 4:3: 0 = each tick, 1 = seconds step, 2 = minutes step, 3 = hours step. The flag (control bit 7) is set on the edge of the Nth event, where N is the limit (address 1), and a limit of 0 means 256 events.
- R7: With control bit 2 at 0 (auto-reload), the counter restarts from 0 at a match, the enable bit stays 1, and the flag sets again after N more events.
- R8: With control bit 2 at 1 (one-shot), a match clears the enable bit, and later events raise no flag.
- R9: A cycle with the enable bit at 0 clears the interval counter, so that after re-enabling, a full N events are needed.
- R10: The flag stays set until a control write with bit 7 at 0. A write with bit 7 at 1 does not set it. irq_o always equals the flag.
- R11: Reads return: address 0 the control byte ({flag, 0, 0, timebase[1:0], one-shot, enable, run}), address 1 the limit, addresses 2..5 the time registers, and addresses 6 and 7 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 128 Hz strobe, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Interval interrupt flag |

## Verification
The bench preloads 23:59:59.127 and checks that a single tick ripples through all four counters. A broken carry chain would leave a stale hour or minute. It loads out-of-range seconds and writes a counter in the same cycle as its own carry, where a design using equality-only wrap or post-write carries would count on past 59 or lose a second. It also runs every timebase, the 256-event meaning of a limit of 0, disable-then-enable mid-count, and both reload modes. Here a counter left uncleared fires early, and a one-shot that keeps its enable fires twice.

// File: rtl/interval_rtc_pkg.sv
package interval_rtc_pkg;

   // register addresses
   localparam int unsigned CTRL_ADDR       = 0;
   localparam int unsigned LIMIT_ADDR      = 1;
   localparam int unsigned FIRST_TIME_ADDR = 2;

   // width of the timebase selector, and so the number of chained stages
   localparam int unsigned BASE_W     = 2;
   localparam int unsigned NUM_STAGES = 1 << BASE_W;

   typedef struct packed {
      logic              flag;
      logic [BASE_W-1:0] base;
      logic              oneshot;
      logic              ivl_en;
      logic              run;
   } ctrl_t;

   function automatic int unsigned stage_modulus(int unsigned idx, int unsigned m0,
                                                 int unsigned m1, int unsigned m2,
                                                 int unsigned m3);
      case (idx)
         0:       return m0;
         1:       return m1;
         2:       return m2;
         default: return m3;
      endcase
   endfunction

endpackage

// File: rtl/interval_rtc_stage.sv
module interval_rtc_stage #(
   parameter int unsigned MOD = 60,
   parameter int unsigned W   = $clog2(MOD)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         step_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] count_o,
   output logic         carry_o
);

   localparam logic [W-1:0] TOP = W'(MOD - 1);

   if (MOD < 2) begin : g_bad_mod
      $error("interval_rtc_stage: MOD must be at least 2");
   end
   if ((1 << W) < MOD) begin : g_bad_width
      $error("interval_rtc_stage: W too narrow for MOD");
   end

   logic [W-1:0] count_q;
   logic         at_top;

   assign at_top  = (count_q >= TOP);
   assign carry_o = step_i & at_top;
   assign count_o = count_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     count_q <= '0;
      else if (load_i) count_q <= load_val_i;
      else if (step_i) count_q <= at_top ? '0 : count_q + 1'b1;
   end

   // R3: a step at or beyond the top returns the count to zero
   assert_wrap_to_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i && at_top && !load_i |=> count_q == '0);

   // R5: a load takes the written value
   assert_load_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> count_q == $past(load_val_i));

endmodule

// File: rtl/interval_rtc_ivl.sv
module interval_rtc_ivl #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic             event_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             match_o
);

   if (CNT_W < 1) begin : g_bad_width
      $error("interval_rtc_ivl: CNT_W must be positive");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             hit;

   assign cnt_inc = cnt_q + 1'b1;
   assign hit     = (cnt_inc == limit_i);
   assign match_o = enable_i & event_i & hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cnt_q <= '0;
      else if (!enable_i) cnt_q <= '0;
      else if (event_i)   cnt_q <= hit ? '0 : cnt_inc;
   end

   // R9: a disabled cycle leaves the counter at zero
   assert_disable_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> cnt_q == '0);

   // R7: the count restarts after every match
   assert_restart_after_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_o |=> cnt_q == '0);

   // R6: no event, no movement
   assert_hold_without_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enable_i && !event_i |=> $stable(cnt_q));

endmodule

// File: rtl/interval_rtc.sv
module interval_rtc #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned LIMIT_W  = 8,
   parameter int unsigned FRAC_MOD = 128,
   parameter int unsigned SEC_MOD  = 60,
   parameter int unsigned MIN_MOD  = 60,
   parameter int unsigned HOUR_MOD = 24
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o
);
   import interval_rtc_pkg::*;

   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(LIMIT_ADDR);

   if (DATA_W < 8) begin : g_bad_data
      $error("interval_rtc: DATA_W must be at least 8");
   end
   if (LIMIT_W > DATA_W) begin : g_bad_limit
      $error("interval_rtc: LIMIT_W exceeds DATA_W");
   end
   if ((1 << ADDR_W) < FIRST_TIME_ADDR + NUM_STAGES) begin : g_bad_addr
      $error("interval_rtc: ADDR_W too narrow for the register set");
   end

   ctrl_t                          ctrl_q;
   logic [LIMIT_W-1:0]             limit_q;
   logic [NUM_STAGES-1:0]          stage_step;
   logic [NUM_STAGES-1:0]          stage_carry;
   logic [NUM_STAGES-1:0][DATA_W-1:0] stage_val;
   logic                           wr_ctrl;
   logic                           wr_limit;
   logic                           sel_event;
   logic                           ivl_match;

   assign wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
   assign wr_limit = wr_en_i && (wr_addr_i == A_LIMIT);

   // ---------------- time-of-day chain ----------------
   assign stage_step[0] = tick_i & ctrl_q.run;

   for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
      localparam int unsigned SMOD = stage_modulus(i, FRAC_MOD, SEC_MOD, MIN_MOD, HOUR_MOD);
      localparam int unsigned SW   = $clog2(SMOD);
      localparam logic [ADDR_W-1:0] SADDR = ADDR_W'(FIRST_TIME_ADDR + i);

      if (SW > DATA_W) begin : g_bad_stage
         $error("interval_rtc: stage wider than DATA_W");
      end

      logic [SW-1:0] st_count;

      interval_rtc_stage #(.MOD(SMOD), .W(SW)) i_stage (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .step_i     (stage_step[i]),
         .load_i     (wr_en_i && (wr_addr_i == SADDR)),
         .load_val_i (wr_data_i[SW-1:0]),
         .count_o    (st_count),
         .carry_o    (stage_carry[i])
      );

      assign stage_val[i] = DATA_W'(st_count);

      if (i + 1 < NUM_STAGES) begin : g_link
         assign stage_step[i+1] = stage_carry[i];
      end
   end

   // ---------------- interval timer ----------------
   assign sel_event = stage_step[ctrl_q.base];

   interval_rtc_ivl #(.CNT_W(LIMIT_W)) i_ivl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .enable_i (ctrl_q.ivl_en),
      .event_i  (sel_event),
      .limit_i  (limit_q),
      .match_o  (ivl_match)
   );

   // ---------------- control and limit registers ----------------
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q  <= '0;
         limit_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.run     <= wr_data_i[0];
            ctrl_q.ivl_en  <= wr_data_i[1];
            ctrl_q.oneshot <= wr_data_i[2];
            ctrl_q.base    <= wr_data_i[4:3];
         end else if (ivl_match && ctrl_q.oneshot) begin
            ctrl_q.ivl_en  <= 1'b0;
         end

         if (ivl_match)                      ctrl_q.flag <= 1'b1;
         else if (wr_ctrl && !wr_data_i[7])  ctrl_q.flag <= 1'b0;

         if (wr_limit) limit_q <= wr_data_i[LIMIT_W-1:0];
      end
   end

   assign irq_o = ctrl_q.flag;

   // ---------------- read mux ----------------
   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == A_CTRL) begin
         rd_data_o = DATA_W'({ctrl_q.flag, 2'b00, ctrl_q.base, ctrl_q.oneshot,
                              ctrl_q.ivl_en, ctrl_q.run});
      end else if (rd_addr_i == A_LIMIT) begin
         rd_data_o = DATA_W'(limit_q);
      end else begin
         for (int k = 0; k < NUM_STAGES; k++) begin
            if (rd_addr_i == ADDR_W'(FIRST_TIME_ADDR + k)) rd_data_o = stage_val[k];
         end
      end
   end

   // R6: the flag only rises on an interval match
   assert_flag_from_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ctrl_q.flag) |-> $past(ivl_match));

   // R8: a one-shot match drops the enable bit
   assert_oneshot_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ivl_match && ctrl_q.oneshot && !wr_ctrl |=> !ctrl_q.ivl_en);

   // R4: a stopped clock keeps the time registers
   assert_frozen_time_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_q.run && !wr_en_i |=> $stable(stage_val));

   // R10: the flag holds without a control write
   assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_q.flag && !wr_ctrl |=> ctrl_q.flag);

   // R3: an hour wrap leaves the hour at zero
   assert_day_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stage_carry[NUM_STAGES-1] && !wr_en_i |=> stage_val[NUM_STAGES-1] == '0);

endmodule

// File: tb/test_interval_rtc.sv
`timescale 1ns/1ps
module test_interval_rtc;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       irq;

   always #2.5 clk = ~clk;

   interval_rtc i_interval_rtc (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .tick_i    (tick),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data),
      .irq_o     (irq)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   // behavioural reference state
   int m_frac = 0, m_sec = 0, m_min = 0, m_hour = 0;
   int m_lim = 0, m_cnt = 0, m_base = 0;
   bit m_run = 0, m_en = 0, m_one = 0, m_flag = 0;

   always @(posedge clk) begin : ref_model
      bit s0, c0, c1, c2, c3, ev, match, ctrl_wr;
      int inc;
      if (!rst_n) begin
         m_frac = 0; m_sec = 0; m_min = 0; m_hour = 0;
         m_lim = 0; m_cnt = 0; m_base = 0;
         m_run = 0; m_en = 0; m_one = 0; m_flag = 0;
      end else begin
         s0 = tick && m_run;
         c0 = s0 && (m_frac >= 127);
         c1 = c0 && (m_sec >= 59);
         c2 = c1 && (m_min >= 59);
         c3 = c2 && (m_hour >= 23);
         case (m_base)
            0: ev = s0;
            1: ev = c0;
            2: ev = c1;
            default: ev = c2;
         endcase
         inc = (m_cnt + 1) % 256;
         match = m_en && ev && (inc == m_lim);
         ctrl_wr = wr_en && (wr_addr == 0);
         if (!m_en) m_cnt = 0;
         else if (ev) m_cnt = match ? 0 : inc;
         if (s0) m_frac = c0 ? 0 : m_frac + 1;
         if (c0) m_sec  = c1 ? 0 : m_sec + 1;
         if (c1) m_min  = c2 ? 0 : m_min + 1;
         if (c2) m_hour = c3 ? 0 : m_hour + 1;
         if (match) m_flag = 1;
         else if (ctrl_wr && !wr_data[7]) m_flag = 0;
         if (ctrl_wr) begin
            m_run = wr_data[0]; m_en = wr_data[1]; m_one = wr_data[2];
            m_base = int'(wr_data[4:3]);
         end else if (match && m_one) begin
            m_en = 0;
         end
         if (wr_en) begin
            case (wr_addr)
               3'd1: m_lim  = int'(wr_data);
               3'd2: m_frac = int'(wr_data) & 127;
               3'd3: m_sec  = int'(wr_data) & 63;
               3'd4: m_min  = int'(wr_data) & 63;
               3'd5: m_hour = int'(wr_data) & 31;
               default: ;
            endcase
         end
      end
   end

   function automatic int model_read(int a);
      case (a)
         0: return (int'(m_flag) << 7) | (m_base << 3) | (int'(m_one) << 2) |
                   (int'(m_en) << 1) | int'(m_run);
         1: return m_lim;
         2: return m_frac;
         3: return m_sec;
         4: return m_min;
         5: return m_hour;
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(int a);
      case (a)
         0: return "R6";
         2: return "R2";
         3, 4, 5: return "R3";
         default: return "R11";
      endcase
   endfunction

   task automatic check(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check({tag_of(int'(rd_addr)), " per-cycle read"}, int'(rd_data), model_read(int'(rd_addr)));
         check("R10 per-cycle irq", int'(irq), int'(m_flag));
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit tk = 0);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d; tick = tk;
      @(posedge clk); #1;
      wr_en = 1'b0; tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(posedge clk); #1;
      tick = 1'b1;
      repeat (n) @(posedge clk);
      #1 tick = 1'b0;
   endtask

   task automatic read_chk(input logic [2:0] a, input int exp, input string tag);
      @(posedge clk); #1;
      rd_addr = a;
      @(negedge clk);
      check(tag, int'(rd_data), exp);
   endtask

   task automatic irq_chk(input int exp, input string tag);
      @(negedge clk);
      check(tag, int'(irq), exp);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 6; a++) read_chk(3'(a), 0, "R1 reset value");
      irq_chk(0, "R1 irq after reset");

      // R2 sub-second count and carry
      wr(3'd0, 8'h01);
      ticks(130);
      read_chk(3'd2, 2, "R2 1/128 count after 130 ticks");
      read_chk(3'd3, 1, "R2 seconds after 130 ticks");

      // R3 full-day wrap and hour carry
      wr(3'd5, 8'd23); wr(3'd4, 8'd59); wr(3'd3, 8'd59); wr(3'd2, 8'd127);
      ticks(1);
      read_chk(3'd2, 0, "R3 day wrap frac");
      read_chk(3'd3, 0, "R3 day wrap sec");
      read_chk(3'd4, 0, "R3 day wrap min");
      read_chk(3'd5, 0, "R3 day wrap hour");
      wr(3'd5, 8'd5); wr(3'd4, 8'd59); wr(3'd3, 8'd59); wr(3'd2, 8'd127);
      ticks(1);
      read_chk(3'd5, 6, "R3 hour carry");
      read_chk(3'd4, 0, "R3 minute wrap");

      // R4 stopped clock
      wr(3'd0, 8'h00);
      ticks(10);
      read_chk(3'd2, 0, "R4 frac held");
      read_chk(3'd5, 6, "R4 hour held");

      // R5 loads, masking, out-of-range wrap, old-value carry
      wr(3'd3, 8'd62);
      read_chk(3'd3, 62, "R5 seconds load");
      wr(3'd2, 8'hFF);
      read_chk(3'd2, 127, "R5 frac load masked");
      wr(3'd0, 8'h01);
      ticks(1);
      read_chk(3'd3, 0, "R5 out-of-range seconds wrap");
      read_chk(3'd4, 1, "R5 carry from out-of-range seconds");
      wr(3'd2, 8'd127);
      wr(3'd2, 8'd5, 1);
      read_chk(3'd2, 5, "R5 write beats step");
      read_chk(3'd3, 1, "R5 carry from old value");

      // R6 tick timebase, R10 clear
      wr(3'd1, 8'd5); wr(3'd0, 8'h03);
      ticks(4);
      irq_chk(0, "R6 no flag before limit");
      ticks(1);
      irq_chk(1, "R6 flag at limit");
      read_chk(3'd0, 8'h83, "R6 control with flag");
      wr(3'd0, 8'h03);
      read_chk(3'd0, 8'h03, "R10 flag cleared by write");
      irq_chk(0, "R10 irq low after clear");

      // R7 reload
      ticks(5);
      irq_chk(1, "R7 flag after reload");
      read_chk(3'd0, 8'h83, "R7 enable kept");
      wr(3'd0, 8'h03);
      wr(3'd0, 8'h83);
      read_chk(3'd0, 8'h03, "R10 writing one does not set flag");

      // R8 one-shot
      wr(3'd1, 8'd3); wr(3'd0, 8'h07);
      ticks(3);
      irq_chk(1, "R8 one-shot flag");
      read_chk(3'd0, 8'h85, "R8 enable cleared");
      wr(3'd0, 8'h05);
      ticks(10);
      irq_chk(0, "R8 no further flag");

      // R9 disable clears count
      wr(3'd1, 8'd4); wr(3'd0, 8'h03);
      ticks(3);
      wr(3'd0, 8'h01); wr(3'd0, 8'h03);
      ticks(3);
      irq_chk(0, "R9 counter restarted");
      ticks(1);
      irq_chk(1, "R9 full interval after re-enable");

      // R6 seconds timebase
      wr(3'd0, 8'h01); wr(3'd1, 8'd2); wr(3'd2, 8'd127); wr(3'd0, 8'h0B);
      ticks(1);
      irq_chk(0, "R6 seconds base first event");
      wr(3'd2, 8'd127);
      ticks(1);
      irq_chk(1, "R6 seconds base second event");

      // R6 minutes timebase
      wr(3'd0, 8'h01); wr(3'd1, 8'd1); wr(3'd3, 8'd10); wr(3'd2, 8'd127); wr(3'd0, 8'h13);
      ticks(1);
      irq_chk(0, "R6 minutes base ignores seconds step");
      wr(3'd3, 8'd59); wr(3'd2, 8'd127);
      ticks(1);
      irq_chk(1, "R6 minutes base event");

      // R6 hours timebase
      wr(3'd0, 8'h01); wr(3'd4, 8'd59); wr(3'd3, 8'd59); wr(3'd2, 8'd127); wr(3'd0, 8'h1B);
      ticks(1);
      irq_chk(1, "R6 hours base event");

      // R6 limit 0 means 256 events
      wr(3'd0, 8'h01); wr(3'd1, 8'd0); wr(3'd0, 8'h03);
      ticks(255);
      irq_chk(0, "R6 limit zero before 256");
      ticks(1);
      irq_chk(1, "R6 limit zero at 256");

      // R11 unused addresses
      read_chk(3'd6, 0, "R11 address 6");
      read_chk(3'd7, 0, "R11 address 7");
      read_chk(3'd1, 0, "R11 limit readback");

      finish_run();
   end

endmodule